// File: doc/BRIEF.md
# Multiplexed Seven-Segment Digit Driver

This block drives a group of common-anode seven-segment displays by lighting one digit per clock cycle. Each clock edge moves the lit position one step along a fixed rotating sequence. It takes binary values and splits each into a tens digit and a units digit itself. It then encodes the digit in the lit position onto a shared active-low segment bus, and raises the matching anode select.

There are two configurations. The four-digit form shows a time of day: an hour value and a minute value, scanned as hour tens, hour units, minute tens, minute units. The two-digit form shows one temperature value, scanned as tens then units. With a 120 Hz clock, the four-digit group completes a full scan 30 times a second, which is fast enough for the eye to see a steady display.

Top module: `seg7_mux_driver`

## Requirements
- R1: `sel_o` is one-hot at all times, and the single high bit is the anode of the digit being lit.
- R2: While `rst_ni` is low, and in the first cycle after it is released, `sel_o` selects position 0. Position 0 is the tens digit of `val_hi_i`.
- R3: On each rising clock edge the lit position advances by one, from position k to position k+1, and wraps from NUM_DIGITS-1 back to 0. Position p is `sel_o[p]`.
- R4: Segments are active-low: a 0 on `seg_no` lights the segment. A digit 8 drives all seven bits to 0.
- R5: `seg_no` bit 0 drives segment a, and the bits continue in order through bit 6, which drives segment g. Digits 0 to 9 use the usual shapes. As active-low hex these are 0:40, 1:79, 2:24, 3:30, 4:19, 5:12, 6:02, 7:78, 8:00, 9:10.
- R6: Each value v is split into tens = v/10 and units = v mod 10. Positions 0 and 1 show the tens and units of `val_hi_i`. Positions 2 and 3 show the tens and units of `val_lo_i`.
- R7: A digit code above 9 blanks the display: `seg_no` is 7'h7F. This happens when a value is 100 or more, because the tens digit is then 10 or greater.
- R8: In the two-digit configuration, `sel_o` is 2 bits wide and `val_lo_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock; one digit is lit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| val_hi_i | input | VAL_W | Hour value (four-digit form) or temperature value (two-digit form) |
| val_lo_i | input | VAL_W | Minute value; unused in the two-digit form |
| seg_no | output | 7 | Segments g..a, active low |
| sel_o | output | NUM_DIGITS | Anode selects, one-hot, active high |

## Verification
The only state in this block is the scan position. If that position is wrong, the error shows at the ports on the very next cycle: either the anode select is wrong, or the select is right but the segment pattern belongs to a different digit. A bench model that steps its own position once per clock and is compared on every cycle therefore catches a skipped, repeated or wrongly started position within one scan period. Errors in the digit split and the encoder show up as soon as a value is applied that exercises the faulty digit. Values of 100 and above cover the blanking path.

// File: rtl/seg7_mux_pkg.sv
package seg7_mux_pkg;
  localparam int SEG_W   = 7;
  localparam int DIGIT_W = 4;

  // lit pattern, bit0 = a ... bit6 = g, active high
  function automatic logic [SEG_W-1:0] seg_shape(input logic [DIGIT_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg7_digit_split.sv
module seg7_digit_split
  import seg7_mux_pkg::*;
#(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W-1:0]   val_i,
  output logic [DIGIT_W-1:0] tens_o,
  output logic [DIGIT_W-1:0] units_o
);
  localparam int TENS_MAX = 9;
  logic [VAL_W-1:0] tens_full;
  logic [VAL_W-1:0] units_full;

  always_comb begin
    tens_full  = val_i / VAL_W'(10);
    units_full = val_i % VAL_W'(10);
    // out-of-range tens saturates to a code the encoder blanks
    tens_o  = (tens_full > VAL_W'(TENS_MAX)) ? '1 : tens_full[DIGIT_W-1:0];
    units_o = units_full[DIGIT_W-1:0];
  end
endmodule

// File: rtl/seg7_scan.sv
module seg7_scan #(
  parameter int NUM_DIGITS = 4,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [IDX_W-1:0]      idx_o,
  output logic [NUM_DIGITS-1:0] sel_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                idx_q <= '0;
    else if (idx_q == IDX_W'(NUM_DIGITS - 1))   idx_q <= '0;
    else                                        idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    sel_o = '0;
    sel_o[idx_q] = 1'b1;
  end
  assign idx_o = idx_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_o)); // R1
  AST_SEL_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sel_o == {$past(sel_o[NUM_DIGITS-2:0]), $past(sel_o[NUM_DIGITS-1])}); // R3
endmodule

// File: rtl/seg7_encode.sv
module seg7_encode
  import seg7_mux_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SEG_W-1:0]   seg_no
);
  always_comb begin
    if (digit_i > DIGIT_W'(9)) seg_no = '1;
    else                       seg_no = ~seg_shape(digit_i);
  end
endmodule

// File: rtl/seg7_mux_driver.sv
module seg7_mux_driver
  import seg7_mux_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int VAL_W      = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [VAL_W-1:0]      val_hi_i,
  input  logic [VAL_W-1:0]      val_lo_i,
  output logic [SEG_W-1:0]      seg_no,
  output logic [NUM_DIGITS-1:0] sel_o
);
  localparam int NUM_VALS = NUM_DIGITS / 2;
  localparam int IDX_W    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [DIGIT_W-1:0] digits [NUM_DIGITS];
  logic [IDX_W-1:0]   idx;
  logic [DIGIT_W-1:0] cur_digit;

  for (genvar p = 0; p < NUM_VALS; p++) begin : g_val
    logic [VAL_W-1:0] val;
    assign val = (p == 0) ? val_hi_i : val_lo_i;
    seg7_digit_split #(.VAL_W(VAL_W)) u_split (
      .val_i  (val),
      .tens_o (digits[2*p]),
      .units_o(digits[2*p+1])
    );
  end

  if (NUM_VALS < 2) begin : g_no_lo
    logic unused_lo;
    assign unused_lo = ^val_lo_i;
  end

  seg7_scan #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_o (idx),
    .sel_o (sel_o)
  );

  assign cur_digit = digits[idx];

  seg7_encode u_enc (
    .digit_i(cur_digit),
    .seg_no (seg_no)
  );

  AST_BLANK_HIGH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_digit > DIGIT_W'(9)) |-> (seg_no == '1)); // R7
  AST_VALID_CODE_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_digit <= DIGIT_W'(9)) |-> (seg_no != '1)); // R4
endmodule

// File: tb/seg7_mux_driver_tb_top.sv
module seg7_mux_driver_tb_top;
  localparam int VW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] hi = '0, lo = '0;
  logic [6:0] seg4, seg2;
  logic [3:0] sel4;
  logic [1:0] sel2;
  int errs = 0, checks = 0;
  int ptr4 = 0, ptr2 = 0;
  bit done = 0;

  always #10 clk = ~clk;

  seg7_mux_driver #(.NUM_DIGITS(4), .VAL_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .val_hi_i(hi), .val_lo_i(lo),
    .seg_no(seg4), .sel_o(sel4));
  seg7_mux_driver #(.NUM_DIGITS(2), .VAL_W(VW)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n), .val_hi_i(hi), .val_lo_i(lo),
    .seg_no(seg2), .sel_o(sel2));

  function automatic logic [6:0] exp_seg(int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; 9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic int exp_digit(int h, int l, int p);
    int v;
    v = (p < 2) ? h : l;
    return (p % 2 == 0) ? v / 10 : v % 10;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference scan position
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ptr4 <= 0; ptr2 <= 0; end
    else begin ptr4 <= (ptr4 + 1) % 4; ptr2 <= (ptr2 + 1) % 2; end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int d4, d2;
      d4 = exp_digit(hi, lo, ptr4);
      d2 = exp_digit(hi, 0, ptr2);
      check("R1/R3 sel4", sel4, 1 << ptr4);
      check(d4 > 9 ? "R7 seg4" : "R5/R6 seg4", seg4, exp_seg(d4));
      check("R8 sel2", sel2, 1 << ptr2);
      check(d2 > 9 ? "R7/R8 seg2" : "R8 seg2", seg2, exp_seg(d2));
    end
  end

  task automatic set_vals(input int h, input int l);
    @(posedge clk); #1;
    hi = VW'(h); lo = VW'(l);
  endtask

  initial begin
    #5;
    check("R2 sel4 in reset", sel4, 1);
    check("R2 sel2 in reset", sel2, 1);
    hi = 7'd12; lo = 7'd34;
    #1 check("R2 seg4 hour tens in reset", seg4, exp_seg(1));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // time of day sweep
    for (int h = 0; h < 24; h++) set_vals(h, (h * 7 + 3) % 60);
    for (int m = 0; m < 60; m++) begin
      set_vals(23, m); @(posedge clk); @(posedge clk);
    end
    // full range, including blanking values
    for (int i = 0; i < 300; i++) set_vals((i * 37) % 128, (i * 53) % 128);
    // R4 all segments lit for 88
    set_vals(88, 88);
    @(negedge clk); check("R4 all lit", seg4, 7'h00);
    // R7 explicit blank on tens of 127
    set_vals(127, 127);
    repeat (4) begin
      @(negedge clk);
      if (sel4[0]) check("R7 blank tens", seg4, 7'h7F);
    end
    // R8 two-digit group ignores lo
    set_vals(31, 0);
    for (int i = 0; i < 20; i++) set_vals(31, i * 6);
    // mid-run reset
    @(posedge clk); #3;
    rst_n = 1'b0;
    #2 check("R2 sel4 mid reset", sel4, 1);
    check("R2 sel2 mid reset", sel2, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    for (int i = 0; i < 40; i++) set_vals(i, 59 - i);
    @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule